// File: doc/BRIEF.md
# Interrupt Remapping and Filtering Unit

This block sits on the interrupt message path between I/O devices and the processors. Every incoming message carries the ID of the device that sent it. The block sorts each message into a delivery class. It then blocks the message, passes it on unchanged, or rewrites it through a per-device remapping table held in memory. Whether a class is allowed, and how, comes from a per-device control entry. The block reads that entry through a combinational lookup port keyed by the device ID.

The two edge-triggered local interrupt lines arrive as strobes beside the message. Fixed and arbitrated interrupts may be remapped. For those, the low 11 bits of the message data select a 32-bit word in the device's table. That word supplies a new vector, destination and delivery mode. The block works on one message at a time. Each accepted message produces exactly one output beat, and that beat is either forwarded or flagged as blocked. The table read takes a variable number of cycles.

Top module: `irq_remap_unit`

## Requirements
- R1: The class comes from the input strobes and `in_data_i[10:8]`. `in_lint0_i` selects LINT0 and overrides everything else. If it is low, `in_lint1_i` selects LINT1. Otherwise the data bits decode as 000 fixed, 001 arbitrated, 100 NMI, 101 INIT and 111 ExtInt. The codes 010, 011 and 110 are always blocked.
- R2: The five legacy classes are each gated by one bit of `ctl_pass_i`: bit 0 INIT, bit 1 NMI, bit 2 LINT0, bit 3 LINT1, bit 4 ExtInt. A set bit passes the message unchanged. A clear bit blocks it.
- R3: Fixed and arbitrated messages follow `ctl_fixed_pol_i`: 00 blocks, 01 passes unchanged, 10 remaps and 11 blocks. No table read is issued unless the message is remapped.
- R4: A remap issues one table read at byte address `ctl_base_i + 4*in_data_i[10:0]`, taken modulo 2^ADDR_W, so the address is always word aligned.
- R5: A remap uses the table entry fields as follows. Bits 23:16 replace `out_data_o[7:0]` (the vector). Bits 4:2 replace `out_data_o[10:8]` (the delivery mode). Bits 15:8 become `out_dest_o`. Data bits above 10 are kept.
- R6: A table entry whose bit 0 is clear blocks the message.
- R7: Each accepted message yields exactly one output beat carrying its source ID on `out_dev_id_o`. Beats come out in arrival order, and no new message is accepted until the previous beat has been taken. Passed and blocked beats carry the original data and destination. `out_blocked_o` is 1 on a blocked beat and 0 on a forwarded one.
- R8: While a request or an output beat waits for ready, its valid stays high and its payload does not change.
- R9: During reset `in_ready_o` is 1, and `out_valid_o` and `mem_req_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input message valid |
| in_ready_o | output | 1 | Input message accepted when high |
| in_dev_id_i | input | DEV_W | Requester device ID |
| in_data_i | input | DATA_W | Message data (vector, type) |
| in_dest_i | input | 8 | Message destination |
| in_lint0_i | input | 1 | Message is a LINT0 event |
| in_lint1_i | input | 1 | Message is a LINT1 event |
| ctl_dev_id_o | output | DEV_W | Device ID for control lookup |
| ctl_base_i | input | ADDR_W | Remapping table base byte address |
| ctl_pass_i | input | 5 | Per-class pass bits for legacy classes |
| ctl_fixed_pol_i | input | 2 | Policy for fixed and arbitrated messages |
| mem_req_valid_o | output | 1 | Table read request valid |
| mem_req_ready_i | input | 1 | Table read request accepted |
| mem_req_addr_o | output | ADDR_W | Table entry byte address |
| mem_rsp_valid_i | input | 1 | Table read data valid |
| mem_rsp_ready_o | output | 1 | Ready for table read data |
| mem_rsp_data_i | input | 32 | Table entry |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Output beat taken |
| out_dev_id_o | output | DEV_W | Source device of the beat |
| out_data_o | output | DATA_W | Output message data |
| out_dest_o | output | 8 | Output destination |
| out_blocked_o | output | 1 | Beat marks a blocked message |

## Verification
The bench builds the unit with DEV_W=4 and ADDR_W=32. With these values, all sixteen device control entries fit in a small table that is filled at random, so random traffic hits every policy combination. The narrow address lets a table base near the top of the space push `base + 4*index` past 2^32, which exercises the modulo wrap. Random stalls on request ready, response latency and output ready exercise the payload hold rules.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;
  localparam int IDX_W = 11;
  localparam int ENT_W = 32;
  localparam int NPASS = 5;

  localparam int PB_INIT   = 0;
  localparam int PB_NMI    = 1;
  localparam int PB_LINT0  = 2;
  localparam int PB_LINT1  = 3;
  localparam int PB_EXTINT = 4;

  localparam logic [2:0] DT_FIXED  = 3'b000;
  localparam logic [2:0] DT_ARB    = 3'b001;
  localparam logic [2:0] DT_NMI    = 3'b100;
  localparam logic [2:0] DT_INIT   = 3'b101;
  localparam logic [2:0] DT_EXTINT = 3'b111;

  localparam logic [1:0] POL_BLOCK = 2'b00;
  localparam logic [1:0] POL_PASS  = 2'b01;
  localparam logic [1:0] POL_REMAP = 2'b10;

  typedef enum logic [2:0] {
    CL_FIXED, CL_ARB, CL_NMI, CL_INIT, CL_EXTINT, CL_LINT0, CL_LINT1, CL_BAD
  } irq_class_e;

  typedef enum logic [1:0] {ACT_BLOCK, ACT_PASS, ACT_REMAP} irq_act_e;

  typedef struct packed {
    logic       en;
    logic [2:0] mode;
    logic [7:0] dest;
    logic [7:0] vec;
  } remap_ent_t;
endpackage

// File: rtl/irq_classify.sv
module irq_classify
  import irq_remap_pkg::*;
(
  input  logic [2:0] dtype_i,
  input  logic       lint0_i,
  input  logic       lint1_i,
  output irq_class_e cls_o
);
  always_comb begin
    if (lint0_i)      cls_o = CL_LINT0;
    else if (lint1_i) cls_o = CL_LINT1;
    else begin
      unique case (dtype_i)
        DT_FIXED:  cls_o = CL_FIXED;
        DT_ARB:    cls_o = CL_ARB;
        DT_NMI:    cls_o = CL_NMI;
        DT_INIT:   cls_o = CL_INIT;
        DT_EXTINT: cls_o = CL_EXTINT;
        default:   cls_o = CL_BAD;
      endcase
    end
  end
endmodule

// File: rtl/irq_policy.sv
module irq_policy
  import irq_remap_pkg::*;
(
  input  irq_class_e       cls_i,
  input  logic [NPASS-1:0] pass_i,
  input  logic [1:0]       fixed_pol_i,
  output irq_act_e         act_o
);
  function automatic irq_act_e gate(input logic b);
    return b ? ACT_PASS : ACT_BLOCK;
  endfunction

  always_comb begin
    unique case (cls_i)
      CL_INIT:   act_o = gate(pass_i[PB_INIT]);
      CL_NMI:    act_o = gate(pass_i[PB_NMI]);
      CL_LINT0:  act_o = gate(pass_i[PB_LINT0]);
      CL_LINT1:  act_o = gate(pass_i[PB_LINT1]);
      CL_EXTINT: act_o = gate(pass_i[PB_EXTINT]);
      CL_FIXED, CL_ARB: begin
        unique case (fixed_pol_i)
          POL_PASS:  act_o = ACT_PASS;
          POL_REMAP: act_o = ACT_REMAP;
          default:   act_o = ACT_BLOCK;
        endcase
      end
      default:   act_o = ACT_BLOCK;
    endcase
  end
endmodule

// File: rtl/irq_entry_decode.sv
module irq_entry_decode
  import irq_remap_pkg::*;
(
  input  logic [ENT_W-1:0] raw_i,
  output remap_ent_t       ent_o
);
  always_comb begin
    ent_o.en   = raw_i[0];
    ent_o.mode = raw_i[4:2];
    ent_o.dest = raw_i[15:8];
    ent_o.vec  = raw_i[23:16];
  end
endmodule

// File: rtl/irq_remap_unit.sv
module irq_remap_unit
  import irq_remap_pkg::*;
#(
  parameter int DEV_W  = 16,
  parameter int ADDR_W = 52,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DEV_W-1:0]  in_dev_id_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [7:0]        in_dest_i,
  input  logic              in_lint0_i,
  input  logic              in_lint1_i,
  output logic [DEV_W-1:0]  ctl_dev_id_o,
  input  logic [ADDR_W-1:0] ctl_base_i,
  input  logic [4:0]        ctl_pass_i,
  input  logic [1:0]        ctl_fixed_pol_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [31:0]       mem_rsp_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DEV_W-1:0]  out_dev_id_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [7:0]        out_dest_o,
  output logic              out_blocked_o
);
  localparam int OFS_W = IDX_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_OUT} state_e;

  state_e            state_q;
  logic [DEV_W-1:0]  dev_q;
  logic [DATA_W-1:0] data_q;
  logic [7:0]        dest_q;
  logic [ADDR_W-1:0] addr_q;
  logic              blocked_q;

  irq_class_e cls;
  irq_act_e   act;
  remap_ent_t ent;
  logic       in_fire;

  irq_classify i_classify (
    .dtype_i (in_data_i[10:8]),
    .lint0_i (in_lint0_i),
    .lint1_i (in_lint1_i),
    .cls_o   (cls)
  );

  irq_policy i_policy (
    .cls_i       (cls),
    .pass_i      (ctl_pass_i),
    .fixed_pol_i (ctl_fixed_pol_i),
    .act_o       (act)
  );

  irq_entry_decode i_entry (
    .raw_i (mem_rsp_data_i),
    .ent_o (ent)
  );

  assign ctl_dev_id_o    = in_dev_id_i;
  assign in_ready_o      = (state_q == S_IDLE);
  assign in_fire         = in_valid_i && in_ready_o;
  assign mem_req_valid_o = (state_q == S_REQ);
  assign mem_req_addr_o  = addr_q;
  assign mem_rsp_ready_o = (state_q == S_RSP);
  assign out_valid_o     = (state_q == S_OUT);
  assign out_dev_id_o    = dev_q;
  assign out_data_o      = data_q;
  assign out_dest_o      = dest_q;
  assign out_blocked_o   = blocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      dev_q     <= '0;
      data_q    <= '0;
      dest_q    <= '0;
      addr_q    <= '0;
      blocked_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (in_fire) begin
          dev_q     <= in_dev_id_i;
          data_q    <= in_data_i;
          dest_q    <= in_dest_i;
          // byte address of a 4-byte entry, wraps at 2^ADDR_W
          addr_q    <= ctl_base_i + ADDR_W'({in_data_i[IDX_W-1:0], 2'b00});
          blocked_q <= (act == ACT_BLOCK);
          state_q   <= (act == ACT_REMAP) ? S_REQ : S_OUT;
        end
        S_REQ: if (mem_req_ready_i) state_q <= S_RSP;
        S_RSP: if (mem_rsp_valid_i) begin
          blocked_q <= !ent.en;
          if (ent.en) begin
            data_q[10:0] <= {ent.mode, ent.vec};
            dest_q       <= ent.dest;
          end
          state_q <= S_OUT;
        end
        S_OUT: if (out_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic unused_ofs;
  assign unused_ofs = (OFS_W > ADDR_W);
endmodule

// File: rtl/irq_remap_checker.sv
module irq_remap_checker #(
  parameter int DEV_W  = 16,
  parameter int ADDR_W = 52,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              mem_rsp_valid_i,
  input logic              mem_rsp_ready_o,
  input logic [31:0]       mem_rsp_data_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DEV_W-1:0]  out_dev_id_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [7:0]        out_dest_o,
  input logic              out_blocked_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r9: assert (in_ready_o && !out_valid_o && !mem_req_valid_o);
    end
  end

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_dest_o) && $stable(out_blocked_o) && $stable(out_dev_id_o));

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  p_addr_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[1:0] == 2'b00);

  p_single_flight_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> !in_ready_o);

  p_busy_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o && !mem_req_valid_o && !mem_rsp_ready_o);

  p_entry_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i && mem_rsp_ready_o && !mem_rsp_data_i[0] |=> out_valid_o && out_blocked_o);

  p_entry_fields_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i && mem_rsp_ready_o && mem_rsp_data_i[0] |=> out_valid_o && !out_blocked_o
      && out_data_o[7:0] == $past(mem_rsp_data_i[23:16])
      && out_data_o[10:8] == $past(mem_rsp_data_i[4:2])
      && out_dest_o == $past(mem_rsp_data_i[15:8]));
endmodule

bind irq_remap_unit irq_remap_checker #(
  .DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_checker (.*);

// File: tb/test_irq_remap_unit.sv
`timescale 1ns/1ps
module test_irq_remap_unit;
  localparam int DEV_W  = 4;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NDEV   = 1 << DEV_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              in_valid = 0, in_ready;
  logic [DEV_W-1:0]  in_dev = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [7:0]        in_dest = '0;
  logic              in_l0 = 0, in_l1 = 0;
  logic [DEV_W-1:0]  ctl_dev;
  logic [ADDR_W-1:0] ctl_base;
  logic [4:0]        ctl_pass;
  logic [1:0]        ctl_pol;
  logic              req_valid, req_ready = 0;
  logic [ADDR_W-1:0] req_addr;
  logic              rsp_valid = 0, rsp_ready;
  logic [31:0]       rsp_data = '0;
  logic              out_valid, out_ready = 0;
  logic [DEV_W-1:0]  out_dev;
  logic [DATA_W-1:0] out_data;
  logic [7:0]        out_dest;
  logic              out_blocked;

  logic [ADDR_W-1:0] t_base [NDEV];
  logic [4:0]        t_pass [NDEV];
  logic [1:0]        t_pol  [NDEV];

  always_comb begin
    ctl_base = t_base[ctl_dev];
    ctl_pass = t_pass[ctl_dev];
    ctl_pol  = t_pol[ctl_dev];
  end

  irq_remap_unit #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_irq_remap_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_dev_id_i(in_dev),
    .in_data_i(in_data), .in_dest_i(in_dest), .in_lint0_i(in_l0), .in_lint1_i(in_l1),
    .ctl_dev_id_o(ctl_dev), .ctl_base_i(ctl_base), .ctl_pass_i(ctl_pass),
    .ctl_fixed_pol_i(ctl_pol),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_ready_o(rsp_ready), .mem_rsp_data_i(rsp_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_dev_id_o(out_dev),
    .out_data_o(out_data), .out_dest_o(out_dest), .out_blocked_o(out_blocked)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] entry_of(input logic [ADDR_W-1:0] a);
    logic [31:0] h;
    h = (a * 32'h9E37_79B1) ^ (a >> 7);
    return h;
  endfunction

  // expected action: 0 block, 1 pass, 2 remap
  function automatic int exp_act(input logic [DEV_W-1:0] d, input logic [DATA_W-1:0] dat,
                                 input logic l0, input logic l1);
    if (l0) return t_pass[d][2] ? 1 : 0;  // R1 LINT0 first
    if (l1) return t_pass[d][3] ? 1 : 0;
    case (dat[10:8])
      3'b101: return t_pass[d][0] ? 1 : 0;
      3'b100: return t_pass[d][1] ? 1 : 0;
      3'b111: return t_pass[d][4] ? 1 : 0;
      3'b000, 3'b001: return (t_pol[d] == 2'b01) ? 1 : (t_pol[d] == 2'b10) ? 2 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic send(input logic [DEV_W-1:0] d, input logic [DATA_W-1:0] dat,
                      input logic [7:0] dst, input logic l0, input logic l1);
    int act, n, lat;
    bit got_req, got_out, rsp_fire;
    logic [ADDR_W-1:0] e_addr, g_addr;
    logic [31:0] ent;
    logic [DATA_W-1:0] e_data, g_data;
    logic [7:0] e_dest, g_dest;
    logic e_blk, g_blk;
    logic [DEV_W-1:0] g_dev;
    act = exp_act(d, dat, l0, l1);
    e_addr = t_base[d] + {19'd0, dat[10:0], 2'b00};
    ent = entry_of(e_addr);
    e_data = dat; e_dest = dst; e_blk = (act == 0);
    if (act == 2) begin
      if (ent[0]) begin
        e_data[10:0] = {ent[4:2], ent[23:16]};
        e_dest = ent[15:8];
      end else e_blk = 1'b1;
    end
    @(negedge clk);
    out_ready = 0;
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_dev = d; in_data = dat; in_dest = dst; in_l0 = l0; in_l1 = l1;
    @(negedge clk);
    in_valid = 0; in_l0 = 0; in_l1 = 0; in_data = $urandom;
    got_req = 0; got_out = 0; rsp_fire = 0; lat = -1; n = 0;
    g_addr = '0; g_data = '0; g_dest = '0; g_blk = 0; g_dev = '0;
    while (!got_out && n < 400) begin
      if (n != 0) @(negedge clk);
      n++;
      if (rsp_fire) begin rsp_valid = 0; rsp_fire = 0; end
      req_ready = ($urandom % 3) != 0;
      out_ready = ($urandom % 4) != 0;
      if (lat > 0) lat--;
      else if (lat == 0) begin rsp_valid = 1; rsp_data = entry_of(g_addr); end
      if (rsp_valid && rsp_ready) begin rsp_fire = 1; lat = -1; end
      if (req_valid && req_ready) begin
        got_req = 1; g_addr = req_addr; lat = $urandom % 5;
      end
      if (out_valid && out_ready) begin
        got_out = 1; g_data = out_data; g_dest = out_dest; g_blk = out_blocked; g_dev = out_dev;
      end
    end
    @(negedge clk);
    out_ready = 0; req_ready = 0; rsp_valid = 0;
    check(got_out, "R7", "beat produced", {63'd0, got_out}, 64'd1);
    check(g_dev == d, "R7", "source id", 64'(g_dev), 64'(d));
    check(g_blk == e_blk, (act == 2) ? "R6" : "R2", "blocked flag", 64'(g_blk), 64'(e_blk));
    check(g_data == e_data, (act == 2) ? "R5" : "R1", "data", 64'(g_data), 64'(e_data));
    check(g_dest == e_dest, (act == 2) ? "R5" : "R7", "dest", 64'(g_dest), 64'(e_dest));
    if (act == 2) begin
      check(got_req, "R3", "table read issued", {63'd0, got_req}, 64'd1);
      check(g_addr == e_addr, "R4", "table address", 64'(g_addr), 64'(e_addr));
    end else begin
      check(!got_req, "R3", "no table read", {63'd0, got_req}, 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NDEV; i++) begin
      t_base[i] = $urandom & 32'hFFFF_FFFC;
      t_pass[i] = 5'($urandom);
      t_pol[i]  = 2'($urandom);
    end
    t_base[0] = 32'h0000_1000; t_pass[0] = 5'b10101; t_pol[0] = 2'b10;
    t_base[1] = 32'h0002_0000; t_pass[1] = 5'b01010; t_pol[1] = 2'b01;
    t_pol[2] = 2'b00; t_pol[3] = 2'b11;
    t_base[4] = 32'hFFFF_FC00; t_pol[4] = 2'b10;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(in_ready == 1'b1, "R9", "in_ready in reset", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
    check(req_valid == 1'b0, "R9", "req_valid in reset", 64'(req_valid), 64'd0);
    rst_n = 1;
    // R2 legacy classes, set and clear bits
    send(0, 32'h0000_0531, 8'h11, 0, 0);  // INIT pass
    send(1, 32'h0000_0531, 8'h12, 0, 0);  // INIT block
    send(0, 32'h0000_0402, 8'h13, 0, 0);  // NMI block
    send(1, 32'h0000_0402, 8'h14, 0, 0);  // NMI pass
    send(0, 32'h0000_0020, 8'h15, 1, 0);  // LINT0 pass
    send(1, 32'h0000_0020, 8'h16, 1, 0);  // LINT0 block
    send(0, 32'h0000_0021, 8'h17, 0, 1);  // LINT1 block
    send(1, 32'h0000_0021, 8'h18, 0, 1);  // LINT1 pass
    send(1, 32'h0000_0022, 8'h19, 1, 1);  // R1 LINT0 wins -> block
    send(0, 32'h0000_0744, 8'h1A, 0, 0);  // ExtInt pass
    send(1, 32'h0000_0744, 8'h1B, 0, 0);  // ExtInt block
    // R3 policies
    send(2, 32'h0000_0050, 8'h21, 0, 0);
    send(1, 32'h1234_0050, 8'h22, 0, 0);
    send(3, 32'h0000_0150, 8'h23, 0, 0);
    send(0, 32'hABCD_00FF, 8'h24, 0, 0);  // R5 remap
    send(4, 32'h0000_01FF, 8'h25, 0, 0);  // R4 address wrap
    // R1 undefined codes
    send(1, 32'h0000_0200, 8'h31, 0, 0);
    send(1, 32'h0000_0300, 8'h32, 0, 0);
    send(1, 32'h0000_0600, 8'h33, 0, 0);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      send(DEV_W'($urandom), $urandom, 8'($urandom), r[2:0] == 0, r[5:3] == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule